// File: doc/BRIEF.md
# Power-State Controller with Push-Button Handling

This block is the digital state machine of a power-management device. It moves the device between three power states: OFF, ACTIVE and SLEEP. An active-low push-button wakes the device from OFF or SLEEP once it has been held long enough. After a button wake it keeps the device on for a minimum hold-off window. A press that runs past a long-press threshold raises an interrupt, and if that interrupt is not acknowledged before a timeout the device shuts down. A level-sensitive hold input gives a second, undebounced way to switch the device on and off. The processor keeps the device alive through an enable level and asks for SLEEP through a request level.

The outputs drive one enable line per regulated resource, an enable for the 32 kHz clock output, an active-low processor reset and an interrupt line whose polarity is programmable. The interrupt status bits are held here and are cleared by a write-one-to-clear acknowledge port. The host register interface is modelled as plain ports. Every time interval is a parameter counted in clock ticks.

Top module: `pwr_state_ctrl`

## Requirements
- R1: The button (`btn_n`, low = pressed) is recognised only once it has stayed low for DEB_TICKS consecutive ticks after the two-stage synchroniser; a shorter press causes no state change. A recognised press in OFF moves the device to ACTIVE and sets status bit 0 (button).
- R2: A recognised press in SLEEP moves the device to ACTIVE and sets status bit 0.
- R3: While ACTIVE, a debounced low level on the button sets status bit 0 again on every tick, so an acknowledge has no lasting effect until the button is released.
- R4: After entering ACTIVE, the device stays ACTIVE for at least HOLDOFF_TICKS. When that window has ended, it goes to OFF as soon as none of these enabling conditions is present: `cpu_en` high, button held, hold input high.
- R5: A button held low is an enabling condition. With `cpu_en` low, a press that woke the device keeps it ACTIVE until about LPTO_TICKS after the press began, and then the device goes to OFF.
- R6: In ACTIVE, a press lasting LP_TICKS sets status bit 1 (long press). If bit 1 is still set LPTO_TICKS − LP_TICKS ticks later, the device goes to OFF. If bit 1 has been acknowledged by then, the device stays ACTIVE.
- R7: A rising edge on `hold_in` moves OFF to ACTIVE and sets status bit 2 (hold). A falling edge moves ACTIVE or SLEEP to OFF. While `pwr_block` is high, the device never leaves OFF.
- R8: ACTIVE moves to SLEEP on `sleep_req` only when no status bit is set. The device therefore stays ACTIVE while any status bit is pending.
- R9: In OFF, `cpu_rst_n`, every resource enable and `clk32_en` are low. In ACTIVE and SLEEP, `cpu_rst_n` is high. On the first tick in OFF, all status bits read zero.
- R10: In ACTIVE, all resource enables are high and `clk32_en` follows `clk32_cfg`. In SLEEP, resource i is enabled exactly when `keep_mask[i]` is 1, and `clk32_en` follows `clk32_keep`.
- R11: `irq_out` is asserted when any status bit whose `irq_mask` bit is 0 is set. With `irq_pol` = 0 it is active low; with `irq_pol` = 1 it is active high. Writing 1 to an `irq_ack` bit clears that status bit.
- R12: `pwr_state` reports the state as 0 = OFF, 1 = ACTIVE, 2 = SLEEP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| btn_n | input | 1 | Push-button, low when pressed |
| hold_in | input | 1 | Level-sensitive hold input |
| pwr_block | input | 1 | Power-on disable; keeps the device in OFF |
| cpu_en | input | 1 | Processor enabling condition |
| sleep_req | input | 1 | Processor sleep request |
| irq_ack | input | 3 | Write-one-to-clear strobes for the status bits |
| irq_mask | input | 3 | 1 masks the matching status bit from `irq_out` |
| irq_pol | input | 1 | 0 = active-low interrupt line, 1 = active-high |
| keep_mask | input | N_RES | Per-resource keep-on-in-SLEEP mask |
| clk32_keep | input | 1 | Keep the clock output running in SLEEP |
| clk32_cfg | input | 1 | Clock output enable while ACTIVE |
| res_en | output | N_RES | Per-resource enables |
| clk32_en | output | 1 | 32 kHz clock output enable |
| cpu_rst_n | output | 1 | Processor reset, active low |
| irq_out | output | 1 | Interrupt line |
| irq_status | output | 3 | Status bits: 0 button, 1 long press, 2 hold |
| pwr_state | output | 2 | Current power state |

## Verification
A wrong state register shows at once on `pwr_state`, `cpu_rst_n` and the resource enables, because all three decode the state with no register in between. A press or long-press counter that is off by a few ticks shows as a wake that should not happen, or a missing one, at the debounce boundary. It also shows as a shutdown that comes too early or too late against the long-press timeout, so the press length and the sampling times are placed on both sides of each threshold. A status bit that is lost or left stuck shows on `irq_out` within one tick, and on the SLEEP entry, which a pending bit holds off.

// File: rtl/psc_pkg.sv
package psc_pkg;
   typedef enum logic [1:0] {
      PS_OFF    = 2'd0,
      PS_ACTIVE = 2'd1,
      PS_SLEEP  = 2'd2
   } pstate_t;

   localparam int IRQ_N    = 3;
   localparam int IRQ_BTN  = 0;
   localparam int IRQ_LP   = 1;
   localparam int IRQ_HOLD = 2;
endpackage

// File: rtl/psc_sync.sv
module psc_sync #(
   parameter int W      = 2,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("psc_sync: STAGES must be at least 2");
   end

   logic [W-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            chain[s] <= '0;
         else if (s == 0)
            chain[s] <= d;
         else
            chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/psc_button.sv
module psc_button #(
   parameter int DEB_TICKS  = 4,
   parameter int LP_TICKS   = 60,
   parameter int LPTO_TICKS = 100
) (
   input  logic clk,
   input  logic rst_n,
   input  logic btn_low,
   input  logic lp_pend,
   output logic press_evt,
   output logic btn_down,
   output logic lp_evt,
   output logic lp_expire
);
   localparam int CW      = $clog2(LP_TICKS + 1);
   localparam int LPW     = LPTO_TICKS - LP_TICKS;
   localparam int WW      = $clog2(LPW + 1);
   localparam logic [CW-1:0] DEB_HIT = CW'(DEB_TICKS - 1);
   localparam logic [CW-1:0] LP_HIT  = CW'(LP_TICKS - 1);
   localparam logic [CW-1:0] CNT_TOP = CW'(LP_TICKS);
   localparam logic [WW-1:0] WIN_HIT = WW'(LPW - 1);
   localparam logic [WW-1:0] WIN_TOP = WW'(LPW);

   logic [CW-1:0] press_cnt;
   logic [WW-1:0] win_cnt;

   // press duration, saturating at the long-press threshold
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         press_cnt <= '0;
      else if (!btn_low)
         press_cnt <= '0;
      else if (press_cnt != CNT_TOP)
         press_cnt <= press_cnt + 1'b1;
   end

   // acknowledge window, runs only while the long-press bit is pending
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         win_cnt <= '0;
      else if (!lp_pend)
         win_cnt <= '0;
      else if (win_cnt != WIN_TOP)
         win_cnt <= win_cnt + 1'b1;
   end

   assign press_evt = btn_low && (press_cnt == DEB_HIT);
   assign btn_down  = btn_low && (press_cnt >= DEB_HIT);
   assign lp_evt    = btn_low && (press_cnt == LP_HIT);
   assign lp_expire = lp_pend && (win_cnt == WIN_HIT);
endmodule

// File: rtl/psc_irq.sv
module psc_irq #(
   parameter int N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_vec,
   input  logic [N-1:0] ack_vec,
   input  logic         clear_all,
   input  logic [N-1:0] mask,
   input  logic         pol,
   output logic [N-1:0] status,
   output logic         line
);
   logic any_live;

   for (genvar i = 0; i < N; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            status[i] <= 1'b0;
         else if (clear_all)
            status[i] <= 1'b0;
         else if (set_vec[i])
            status[i] <= 1'b1;
         else if (ack_vec[i])
            status[i] <= 1'b0;
      end
   end

   assign any_live = |(status & ~mask);
   assign line     = pol ? any_live : ~any_live;
endmodule

// File: rtl/psc_fsm.sv
module psc_fsm
   import psc_pkg::*;
#(
   parameter int HOLDOFF_TICKS = 40
) (
   input  logic    clk,
   input  logic    rst_n,
   input  logic    press_evt,
   input  logic    btn_down,
   input  logic    lp_expire,
   input  logic    hold_rise,
   input  logic    hold_fall,
   input  logic    hold_lvl,
   input  logic    cpu_en,
   input  logic    sleep_req,
   input  logic    pwr_block,
   input  logic    pending,
   output pstate_t state,
   output logic    go_off
);
   localparam int HW = $clog2(HOLDOFF_TICKS + 1);
   localparam logic [HW-1:0] HO_END = HW'(HOLDOFF_TICKS);

   pstate_t       nxt;
   logic [HW-1:0] ho_cnt;
   logic          ho_done;
   logic          keep_on;

   assign ho_done = (ho_cnt == HO_END);
   assign keep_on = cpu_en || btn_down || hold_lvl;

   always_comb begin
      nxt = state;
      unique case (state)
         PS_OFF: begin
            if (!pwr_block && (press_evt || hold_rise))
               nxt = PS_ACTIVE;
         end
         PS_ACTIVE: begin
            if (lp_expire || hold_fall)
               nxt = PS_OFF;
            else if (ho_done && !keep_on)
               nxt = PS_OFF;
            else if (sleep_req && !pending)
               nxt = PS_SLEEP;
         end
         PS_SLEEP: begin
            if (hold_fall)
               nxt = PS_OFF;
            else if (press_evt)
               nxt = PS_ACTIVE;
         end
         default: nxt = PS_OFF;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         state <= PS_OFF;
      else
         state <= nxt;
   end

   // hold-off window restarts on every entry into ACTIVE
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ho_cnt <= '0;
      else if (state != PS_ACTIVE && nxt == PS_ACTIVE)
         ho_cnt <= '0;
      else if (state == PS_ACTIVE && !ho_done)
         ho_cnt <= ho_cnt + 1'b1;
   end

   assign go_off = (state != PS_OFF) && (nxt == PS_OFF);
endmodule

// File: rtl/pwr_state_ctrl.sv
module pwr_state_ctrl
   import psc_pkg::*;
#(
   parameter int N_RES         = 8,
   parameter int SYNC_STAGES   = 2,
   parameter int DEB_TICKS     = 4,
   parameter int HOLDOFF_TICKS = 40,
   parameter int LP_TICKS      = 60,
   parameter int LPTO_TICKS    = 100
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             btn_n,
   input  logic             hold_in,
   input  logic             pwr_block,
   input  logic             cpu_en,
   input  logic             sleep_req,
   input  logic [2:0]       irq_ack,
   input  logic [2:0]       irq_mask,
   input  logic             irq_pol,
   input  logic [N_RES-1:0] keep_mask,
   input  logic             clk32_keep,
   input  logic             clk32_cfg,
   output logic [N_RES-1:0] res_en,
   output logic             clk32_en,
   output logic             cpu_rst_n,
   output logic             irq_out,
   output logic [2:0]       irq_status,
   output logic [1:0]       pwr_state
);
   if (N_RES < 1) begin : g_bad_res
      $error("pwr_state_ctrl: N_RES must be at least 1");
   end
   if (DEB_TICKS < 1) begin : g_bad_deb
      $error("pwr_state_ctrl: DEB_TICKS must be at least 1");
   end
   if (LP_TICKS <= DEB_TICKS) begin : g_bad_lp
      $error("pwr_state_ctrl: LP_TICKS must exceed DEB_TICKS");
   end
   if (LPTO_TICKS <= LP_TICKS + 1) begin : g_bad_lpto
      $error("pwr_state_ctrl: LPTO_TICKS must exceed LP_TICKS + 1");
   end
   if (HOLDOFF_TICKS < 1) begin : g_bad_ho
      $error("pwr_state_ctrl: HOLDOFF_TICKS must be at least 1");
   end

   pstate_t        state;
   logic [1:0]     sync_q;
   logic           btn_low_s, hold_s, hold_q;
   logic           hold_rise, hold_fall;
   logic           press_evt, btn_down, lp_evt, lp_expire;
   logic           go_off;
   logic [IRQ_N-1:0] set_vec;
   logic           is_active, is_sleep;

   psc_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({hold_in, ~btn_n}),
      .q     (sync_q)
   );

   assign btn_low_s = sync_q[0];
   assign hold_s    = sync_q[1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         hold_q <= 1'b0;
      else
         hold_q <= hold_s;
   end

   assign hold_rise = hold_s && !hold_q;
   assign hold_fall = !hold_s && hold_q;

   psc_button #(
      .DEB_TICKS  (DEB_TICKS),
      .LP_TICKS   (LP_TICKS),
      .LPTO_TICKS (LPTO_TICKS)
   ) u_button (
      .clk       (clk),
      .rst_n     (rst_n),
      .btn_low   (btn_low_s),
      .lp_pend   (irq_status[IRQ_LP]),
      .press_evt (press_evt),
      .btn_down  (btn_down),
      .lp_evt    (lp_evt),
      .lp_expire (lp_expire)
   );

   psc_fsm #(.HOLDOFF_TICKS(HOLDOFF_TICKS)) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .press_evt (press_evt),
      .btn_down  (btn_down),
      .lp_expire (lp_expire),
      .hold_rise (hold_rise),
      .hold_fall (hold_fall),
      .hold_lvl  (hold_s),
      .cpu_en    (cpu_en),
      .sleep_req (sleep_req),
      .pwr_block (pwr_block),
      .pending   (|irq_status),
      .state     (state),
      .go_off    (go_off)
   );

   assign is_active = (state == PS_ACTIVE);
   assign is_sleep  = (state == PS_SLEEP);

   always_comb begin
      set_vec           = '0;
      set_vec[IRQ_BTN]  = press_evt || (is_active && btn_down);
      set_vec[IRQ_LP]   = lp_evt && is_active;
      set_vec[IRQ_HOLD] = hold_rise;
   end

   psc_irq #(.N(IRQ_N)) u_irq (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_vec   (set_vec),
      .ack_vec   (irq_ack),
      .clear_all (go_off),
      .mask      (irq_mask),
      .pol       (irq_pol),
      .status    (irq_status),
      .line      (irq_out)
   );

   for (genvar r = 0; r < N_RES; r++) begin : g_res
      assign res_en[r] = is_active || (is_sleep && keep_mask[r]);
   end

   assign clk32_en  = (is_active && clk32_cfg) || (is_sleep && clk32_keep);
   assign cpu_rst_n = (state != PS_OFF);
   assign pwr_state = state;
endmodule

// File: rtl/pwr_state_ctrl_checker.sv
module pwr_state_ctrl_checker #(
   parameter int N_RES = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             pwr_block,
   input logic [N_RES-1:0] keep_mask,
   input logic [N_RES-1:0] res_en,
   input logic             clk32_en,
   input logic             cpu_rst_n,
   input logic [2:0]       irq_status,
   input logic [1:0]       pwr_state
);
   // R9: OFF drives every output low
   p_off_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_state == 2'd0) |-> (res_en == '0 && !clk32_en && !cpu_rst_n));

   // R9: status bits are empty on the first tick in OFF
   p_off_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_state == 2'd0 && $past(pwr_state) != 2'd0) |-> (irq_status == 3'b000));

   // R10: SLEEP enables follow the keep mask
   p_sleep_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_state == 2'd2) |-> (res_en == keep_mask && cpu_rst_n));

   // R7: blocked device stays in OFF
   p_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_state == 2'd0 && pwr_block) |=> (pwr_state == 2'd0));

   // R8: pending status prevents SLEEP entry
   p_no_sleep_pend_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_state == 2'd1 && irq_status != 3'b000) |=> (pwr_state != 2'd2));

   // R12: only the three defined encodings appear
   p_state_legal_r12: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_state != 2'd3);
endmodule

bind pwr_state_ctrl pwr_state_ctrl_checker #(.N_RES(N_RES)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .pwr_block  (pwr_block),
   .keep_mask  (keep_mask),
   .res_en     (res_en),
   .clk32_en   (clk32_en),
   .cpu_rst_n  (cpu_rst_n),
   .irq_status (irq_status),
   .pwr_state  (pwr_state)
);

// File: tb/pwr_state_ctrl_test.sv
module pwr_state_ctrl_test;
   localparam int N_RES   = 8;
   localparam int DEB     = 4;
   localparam int HOLDOFF = 40;
   localparam int LP      = 60;
   localparam int LPTO    = 100;
   localparam logic [1:0] S_OFF = 2'd0, S_ACT = 2'd1, S_SLP = 2'd2;

   // press-length vectors: length, cpu_en, woke, still ACTIVE after hold-off
   localparam int NV = 5;
   localparam int V_LEN  [NV] = '{2, DEB-1, DEB+1, 8, 6};
   localparam bit V_CPU  [NV] = '{0, 0, 0, 0, 1};
   localparam bit V_WAKE [NV] = '{0, 0, 1, 1, 1};
   localparam bit V_STAY [NV] = '{0, 0, 0, 0, 1};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic btn_n = 1'b1, hold_in = 1'b0, pwr_block = 1'b0;
   logic cpu_en = 1'b0, sleep_req = 1'b0, irq_pol = 1'b0;
   logic [2:0] irq_ack = '0, irq_mask = '0;
   logic [N_RES-1:0] keep_mask = '0;
   logic clk32_keep = 1'b0, clk32_cfg = 1'b0;
   logic [N_RES-1:0] res_en;
   logic clk32_en, cpu_rst_n, irq_out;
   logic [2:0] irq_status;
   logic [1:0] pwr_state;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;

   always #4 clk = ~clk;

   pwr_state_ctrl #(
      .N_RES(N_RES), .DEB_TICKS(DEB), .HOLDOFF_TICKS(HOLDOFF),
      .LP_TICKS(LP), .LPTO_TICKS(LPTO)
   ) uut (
      .clk(clk), .rst_n(rst_n), .btn_n(btn_n), .hold_in(hold_in),
      .pwr_block(pwr_block), .cpu_en(cpu_en), .sleep_req(sleep_req),
      .irq_ack(irq_ack), .irq_mask(irq_mask), .irq_pol(irq_pol),
      .keep_mask(keep_mask), .clk32_keep(clk32_keep), .clk32_cfg(clk32_cfg),
      .res_en(res_en), .clk32_en(clk32_en), .cpu_rst_n(cpu_rst_n),
      .irq_out(irq_out), .irq_status(irq_status), .pwr_state(pwr_state)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc == 60000) begin
         fails = fails + 1;
         $display("FAIL watchdog: run did not finish, actual %0d cycles expected fewer", cyc);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks = checks + 1;
      if (!ok) begin
         fails = fails + 1;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic chk_eq(input string req, input int act, input int exp);
      chk(act == exp, req, act, exp);
   endtask

   task automatic do_reset();
      btn_n = 1'b1; hold_in = 1'b0; pwr_block = 1'b0; cpu_en = 1'b0;
      sleep_req = 1'b0; irq_ack = '0; irq_mask = '0; irq_pol = 1'b0;
      keep_mask = '0; clk32_keep = 1'b0; clk32_cfg = 1'b0;
      rst_n = 1'b0;
      tick(3);
      rst_n = 1'b1;
      tick(1);
   endtask

   task automatic ack(input logic [2:0] bits);
      irq_ack = bits;
      tick(1);
      irq_ack = '0;
   endtask

   task automatic press(input int len);
      btn_n = 1'b0;
      tick(len);
      btn_n = 1'b1;
   endtask

   initial begin
      do_reset();
      // R9 / R11 / R12: reset state
      chk_eq("R12 reset state", pwr_state, S_OFF);
      chk_eq("R9 reset cpu_rst_n", cpu_rst_n, 0);
      chk_eq("R9 reset res_en", res_en, 0);
      chk_eq("R9 reset clk32_en", clk32_en, 0);
      chk_eq("R11 reset irq_out idle high", irq_out, 1);

      // R1 / R4: table of presses from OFF
      for (int v = 0; v < NV; v++) begin
         do_reset();
         cpu_en = V_CPU[v];
         press(V_LEN[v]);
         tick(4);
         chk_eq("R1 wake on press length", pwr_state, V_WAKE[v] ? S_ACT : S_OFF);
         chk_eq("R1 button status bit", irq_status[0], V_WAKE[v] ? 1 : 0);
         chk_eq("R9 cpu_rst_n follows state", cpu_rst_n, V_WAKE[v] ? 1 : 0);
         tick(HOLDOFF + 10);
         chk_eq("R4 state after hold-off", pwr_state, V_STAY[v] ? S_ACT : S_OFF);
      end

      // R4: still ACTIVE inside the hold-off window
      do_reset();
      press(DEB + 2);
      tick(HOLDOFF - 10);
      chk_eq("R4 inside hold-off", pwr_state, S_ACT);

      // R7 / R11: hold input and interrupt line
      do_reset();
      hold_in = 1'b1;
      tick(4);
      chk_eq("R7 hold rise wakes", pwr_state, S_ACT);
      chk_eq("R7 hold status bit 2", irq_status, 3'b100);
      chk_eq("R11 active-low line asserted", irq_out, 0);
      irq_mask = 3'b100;
      tick(1);
      chk_eq("R11 masked bit ignored", irq_out, 1);
      irq_mask = 3'b000;
      irq_pol = 1'b1;
      tick(1);
      chk_eq("R11 active-high line asserted", irq_out, 1);
      ack(3'b100);
      tick(1);
      chk_eq("R11 W1C clears bit", irq_status, 3'b000);
      chk_eq("R11 active-high line idle", irq_out, 0);
      irq_pol = 1'b0;
      tick(HOLDOFF + 5);
      chk_eq("R4 hold level keeps ACTIVE", pwr_state, S_ACT);
      hold_in = 1'b0;
      tick(5);
      chk_eq("R7 hold fall to OFF", pwr_state, S_OFF);

      // R7: power-on disable blocks the hold rise
      pwr_block = 1'b1;
      hold_in = 1'b1;
      tick(8);
      chk_eq("R7 blocked stays OFF", pwr_state, S_OFF);
      hold_in = 1'b0;
      tick(4);
      pwr_block = 1'b0;
      press(DEB + 2);
      tick(4);
      chk_eq("R7 unblocked press wakes", pwr_state, S_ACT);

      // R8 / R10 / R2: SLEEP entry and wake
      do_reset();
      cpu_en = 1'b1; keep_mask = 8'hA5; clk32_keep = 1'b1; clk32_cfg = 1'b1;
      hold_in = 1'b1;
      tick(4);
      chk_eq("R10 ACTIVE all resources", res_en, 8'hFF);
      chk_eq("R10 ACTIVE clock enable", clk32_en, 1);
      sleep_req = 1'b1;
      tick(6);
      chk_eq("R8 pending bit blocks SLEEP", pwr_state, S_ACT);
      ack(3'b100);
      tick(3);
      chk_eq("R8 SLEEP after ack", pwr_state, S_SLP);
      chk_eq("R10 SLEEP keep mask", res_en, 8'hA5);
      chk_eq("R10 SLEEP clock kept", clk32_en, 1);
      chk_eq("R9 cpu_rst_n high in SLEEP", cpu_rst_n, 1);
      press(DEB + 4);
      tick(4);
      chk_eq("R2 press wakes from SLEEP", pwr_state, S_ACT);
      chk_eq("R2 button status bit", irq_status[0], 1);
      tick(10);
      chk_eq("R8 stays ACTIVE while pending", pwr_state, S_ACT);
      ack(3'b111);
      tick(3);
      chk_eq("R8 back to SLEEP", pwr_state, S_SLP);
      clk32_keep = 1'b0;
      tick(1);
      chk_eq("R10 SLEEP clock dropped", clk32_en, 0);
      hold_in = 1'b0;
      tick(5);
      chk_eq("R7 hold fall from SLEEP", pwr_state, S_OFF);
      chk_eq("R9 OFF enables low", res_en, 0);
      chk_eq("R9 OFF status cleared", irq_status, 3'b000);

      // R3: button level in ACTIVE re-sets the bit while held
      do_reset();
      cpu_en = 1'b1;
      hold_in = 1'b1;
      tick(4);
      ack(3'b111);
      btn_n = 1'b0;
      tick(DEB + 4);
      chk_eq("R3 low level sets bit 0", irq_status[0], 1);
      ack(3'b001);
      tick(1);
      chk_eq("R3 bit re-set while held", irq_status[0], 1);
      btn_n = 1'b1;
      tick(4);
      ack(3'b001);
      tick(1);
      chk_eq("R3 bit clears after release", irq_status[0], 0);

      // R6: long press not acknowledged
      do_reset();
      cpu_en = 1'b1;
      hold_in = 1'b1;
      tick(4);
      btn_n = 1'b0;
      tick(LP - 8);
      chk_eq("R6 no long-press bit early", irq_status[1], 0);
      tick(13);
      chk_eq("R6 long-press bit set", irq_status[1], 1);
      btn_n = 1'b1;
      tick(LPTO - LP - 15);
      chk_eq("R6 ACTIVE before timeout", pwr_state, S_ACT);
      tick(20);
      chk_eq("R6 OFF after timeout", pwr_state, S_OFF);
      chk_eq("R9 status cleared on shutdown", irq_status, 3'b000);

      // R6: long press acknowledged
      do_reset();
      cpu_en = 1'b1;
      hold_in = 1'b1;
      tick(4);
      press(LP + 5);
      tick(2);
      ack(3'b111);
      tick(LPTO);
      chk_eq("R6 acked long press stays ACTIVE", pwr_state, S_ACT);

      // R5: held button keeps the device on up to the timeout
      do_reset();
      btn_n = 1'b0;
      tick(HOLDOFF + 15);
      chk_eq("R5 held past hold-off", pwr_state, S_ACT);
      tick(35);
      chk_eq("R5 held before timeout", pwr_state, S_ACT);
      tick(20);
      chk_eq("R5 OFF at timeout", pwr_state, S_OFF);
      btn_n = 1'b1;
      tick(4);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule